// File: doc/BRIEF.md
# Triggered Decimating Sample Qualifier

This block sits between a converter that produces one sample per clock and the memory that holds a capture. It looks at each sample for a crossing of a programmable level in a chosen direction. A capture always starts at the same point of a repeating waveform, so successive captures line up.

Software or a sequencer arms the block. From then on the block waits for a sample that meets both the level condition and the slope condition. That sample is the first one released to the buffer. After it, one sample out of every N valid input samples is released and the rest are dropped. The converter keeps running at its full rate. The time base is therefore set by the ratio N, not by slowing the converter clock.

The block stays triggered, and keeps releasing samples, until it is armed again. Samples are compared as unsigned binary values.

Top module: `trig_decim_qual`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `triggered` is 0, `qualValid` is 0 and `qualOut` is 0.
- R2: Until `arm` has been pulsed, no input sample can trigger the block and no sample is released, whatever the level and slope inputs are.
- R3: With `slopeFalling` = 0, an armed block fires on a valid sample that is at or above `trigLevel` when the previous valid sample was strictly below it (unsigned compare).
- R4: With `slopeFalling` = 1, an armed block fires on a valid sample that is at or below `trigLevel` when the previous valid sample was strictly above it (unsigned compare).
- R5: The triggering sample is the first sample released. In the cycle after the one in which it is presented, `qualValid` is 1, `qualOut` equals that sample, and `triggered` becomes 1.
- R6: `ratioSel` value k selects N = 2^k, so codes 0, 1, 2 and 3 select N = 1, 2, 4 and 8. Counting the triggering sample as valid sample 0, the samples released are valid samples 0, N, 2N and so on. Cycles with `sampleValid` low do not count. Each release appears one cycle after its input.
- R7: Once triggered, the block stays triggered and keeps its decimation phase until `arm` is pulsed. Further crossings do not restart the count.
- R8: A cycle with `arm` high puts the block in the armed state. In the next cycle `triggered` is 0, `qualValid` is 0 and `qualOut` is 0. A crossing in that same cycle does not fire.
- R9: The ratio in effect is the `ratioSel` value present with the triggering sample. Changes to `ratioSel` while triggered have no effect on the release pattern.
- R10: The previous sample is the last valid sample since reset, whether or not the block was armed when it arrived. The first valid sample after reset can never fire.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | SAMPLE_W | Converter sample, unsigned |
| sampleValid | input | 1 | `sampleIn` carries a new sample this cycle |
| trigLevel | input | SAMPLE_W | Trigger threshold, unsigned |
| slopeFalling | input | 1 | 0 selects a rising crossing, 1 a falling crossing |
| ratioSel | input | RATIO_SEL_W | Decimation code k, giving N = 2^k |
| arm | input | 1 | One-cycle pulse that arms the block and clears the trigger |
| triggered | output | 1 | The block has fired and is releasing samples |
| qualOut | output | SAMPLE_W | Last released sample, cleared by `arm` |
| qualValid | output | 1 | One-cycle strobe: `qualOut` holds a newly released sample |

## Verification
A wrong internal state shows at the ports within one cycle in most cases. A wrong held previous sample makes `triggered` rise one cycle early, one cycle late, or not at all. A lost or reloaded ratio shows as a released sample at the wrong valid-sample index within at most eight valid samples of the trigger. A bad state register shows as `qualValid` pulses while untriggered, or as a trigger that survives an arm pulse. The bench replays every cycle through an independent reference model, so any of these appears as a mismatch in the first cycle in which it differs.

// File: rtl/tdq_pkg.sv
package tdq_pkg;

  // Qualifier sequencing states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2
  } qualState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic emit;    // release the current input sample
    logic clrOut;  // clear the held output sample
  } dpStrobe_t;

endpackage

// File: rtl/tdq_datapath.sv
module tdq_datapath
  import tdq_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] trigLevel,
  input  logic                slopeFalling,
  input  dpStrobe_t           strobe,
  output logic                crossing,
  output logic [SAMPLE_W-1:0] qualOut,
  output logic                qualValid
);

  logic [SAMPLE_W-1:0] prevSample;
  logic                prevSeen;
  logic                riseHit;
  logic                fallHit;

  // History of the last valid sample, kept regardless of arm state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      prevSeen   <= 1'b0;
    end else if (sampleValid) begin
      prevSample <= sampleIn;
      prevSeen   <= 1'b1;
    end
  end

  // Level and slope must both match
  always_comb begin
    riseHit  = (prevSample < trigLevel) && (sampleIn >= trigLevel);
    fallHit  = (prevSample > trigLevel) && (sampleIn <= trigLevel);
    crossing = sampleValid && prevSeen && (slopeFalling ? fallHit : riseHit);
  end

  // Output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualOut   <= '0;
      qualValid <= 1'b0;
    end else begin
      qualValid <= strobe.emit;
      if (strobe.clrOut)    qualOut <= '0;
      else if (strobe.emit) qualOut <= sampleIn;
    end
  end

endmodule

// File: rtl/tdq_control.sv
module tdq_control
  import tdq_pkg::*;
#(
  parameter int RATIO_SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic                   crossing,
  input  logic                   arm,
  input  logic [RATIO_SEL_W-1:0] ratioSel,
  output dpStrobe_t              strobe,
  output logic                   triggered
);

  // Largest N is 2^(2^RATIO_SEL_W - 1); the phase counter spans N-1
  localparam int CNT_W = (1 << RATIO_SEL_W) - 1;

  qualState_t             state;
  logic [RATIO_SEL_W-1:0] ratioReg;
  logic [CNT_W-1:0]       phaseCnt;
  logic [CNT_W:0]         spanN;
  logic [CNT_W:0]         termVal;
  logic                   periodEnd;
  logic                   fire;
  logic                   advance;

  always_comb begin
    spanN     = {{CNT_W{1'b0}}, 1'b1} << ratioReg;
    termVal   = spanN - {{CNT_W{1'b0}}, 1'b1};
    periodEnd = ({1'b0, phaseCnt} == termVal);
    fire      = (state == ST_ARMED) && crossing && !arm;
    advance   = (state == ST_TRIG) && sampleValid && !arm;
    strobe.emit   = fire || (advance && periodEnd);
    strobe.clrOut = arm;
    triggered     = (state == ST_TRIG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ratioReg <= '0;
      phaseCnt <= '0;
    end else begin
      if (arm)       state <= ST_ARMED;
      else if (fire) state <= ST_TRIG;

      // Ratio follows the input only while not triggered
      if (state != ST_TRIG) ratioReg <= ratioSel;

      if (fire)         phaseCnt <= '0;
      else if (advance) phaseCnt <= periodEnd ? '0 : phaseCnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/trig_decim_qual.sv
module trig_decim_qual
  import tdq_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int RATIO_SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [SAMPLE_W-1:0]    sampleIn,
  input  logic                   sampleValid,
  input  logic [SAMPLE_W-1:0]    trigLevel,
  input  logic                   slopeFalling,
  input  logic [RATIO_SEL_W-1:0] ratioSel,
  input  logic                   arm,
  output logic                   triggered,
  output logic [SAMPLE_W-1:0]    qualOut,
  output logic                   qualValid
);

  dpStrobe_t strobe;
  logic      crossing;

  tdq_control #(.RATIO_SEL_W(RATIO_SEL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .crossing    (crossing),
    .arm         (arm),
    .ratioSel    (ratioSel),
    .strobe      (strobe),
    .triggered   (triggered)
  );

  tdq_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sampleIn     (sampleIn),
    .sampleValid  (sampleValid),
    .trigLevel    (trigLevel),
    .slopeFalling (slopeFalling),
    .strobe       (strobe),
    .crossing     (crossing),
    .qualOut      (qualOut),
    .qualValid    (qualValid)
  );

endmodule

// File: rtl/tdq_checker.sv
module tdq_checker #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                sampleValid,
  input logic                arm,
  input logic                triggered,
  input logic [SAMPLE_W-1:0] qualOut,
  input logic                qualValid
);

  // R2: samples are released only while triggered
  a_r2_release_needs_trigger: assert property (@(posedge clk) disable iff (!rstN)
    qualValid |-> triggered);

  // R5: trigger rise carries the triggering sample
  a_r5_first_is_trigger: assert property (@(posedge clk) disable iff (!rstN)
    $rose(triggered) |-> (qualValid && qualOut == $past(sampleIn) && $past(sampleValid)));

  // R6: every release stems from a valid input sample
  a_r6_release_from_valid: assert property (@(posedge clk) disable iff (!rstN)
    qualValid |-> $past(sampleValid));

  // R7: triggered holds until arm
  a_r7_trigger_holds: assert property (@(posedge clk) disable iff (!rstN)
    (triggered && !arm) |=> triggered);

  // R8: arm clears trigger and output
  a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!triggered && !qualValid && qualOut == '0));

endmodule

bind trig_decim_qual tdq_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleIn    (sampleIn),
  .sampleValid (sampleValid),
  .arm         (arm),
  .triggered   (triggered),
  .qualOut     (qualOut),
  .qualValid   (qualValid)
);

// File: tb/trig_decim_qual_bench.sv
module trig_decim_qual_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sampleIn = '0;
  logic       sampleValid = 1'b0;
  logic [7:0] trigLevel = '0;
  logic       slopeFalling = 1'b0;
  logic [1:0] ratioSel = '0;
  logic       arm = 1'b0;
  logic       triggered;
  logic [7:0] qualOut;
  logic       qualValid;

  trig_decim_qual u_trig_decim_qual (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .trigLevel(trigLevel), .slopeFalling(slopeFalling), .ratioSel(ratioSel),
    .arm(arm), .triggered(triggered), .qualOut(qualOut), .qualValid(qualValid)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int failures = 0;
  int relCount = 0;
  bit finished = 0;

  // Settings applied by step at the next falling edge
  logic [7:0] curLevel = '0;
  logic       curSlope = 1'b0;
  logic [1:0] curRatio = '0;

  // Reference model state
  int         mState = 0;  // 0 idle, 1 armed, 2 triggered
  logic [7:0] mPrev = '0;
  bit         mPrevSeen = 0;
  int         mRatio = 0;
  int         mCnt = 0;
  logic [7:0] mOut = '0;
  bit         mQv = 0;

  function automatic bit crossFn(logic [7:0] p, logic [7:0] c, logic [7:0] l, logic f);
    if (!f) return (p < l) && (c >= l);
    return (p > l) && (c <= l);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mState = 0; mPrev = '0; mPrevSeen = 0; mRatio = 0; mCnt = 0; mOut = '0; mQv = 0;
  endtask

  task automatic modelAdvance(logic sv, logic [7:0] s, logic a);
    bit emit = 0;
    int oldState = mState;
    int n = 1 << mRatio;
    if (a) mState = 1;
    else if (oldState == 1 && sv && mPrevSeen && crossFn(mPrev, s, curLevel, curSlope)) begin
      mState = 2; emit = 1; mCnt = 0;
    end else if (oldState == 2 && sv) begin
      if (mCnt == n - 1) begin emit = 1; mCnt = 0; end
      else mCnt++;
    end
    if (oldState != 2) mRatio = int'(curRatio);
    if (sv) begin mPrev = s; mPrevSeen = 1; end
    mQv = emit;
    if (a) mOut = '0;
    else if (emit) mOut = s;
  endtask

  task automatic step(logic sv, logic [7:0] s, logic a, string tag);
    @(negedge clk);
    sampleValid = sv; sampleIn = s; arm = a;
    trigLevel = curLevel; slopeFalling = curSlope; ratioSel = curRatio;
    modelAdvance(sv, s, a);
    @(posedge clk);
    #1;
    if (qualValid) relCount++;
    check(qualValid == mQv, tag, "qualValid", int'(qualValid), int'(mQv));
    check(triggered == (mState == 2), tag, "triggered", int'(triggered), int'(mState == 2));
    check(qualOut == mOut, tag, "qualOut", int'(qualOut), int'(mOut));
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(triggered == 0, "R1", "triggered in reset", int'(triggered), 0);
    check(qualValid == 0, "R1", "qualValid in reset", int'(qualValid), 0);
    check(qualOut == 0, "R1", "qualOut in reset", int'(qualOut), 0);
    @(negedge clk); rstN = 1'b1;
    step(0, 8'd0, 0, "R1");

    // R10: first valid sample after reset cannot fire; arm first
    curLevel = 8'd10; curSlope = 0; curRatio = 2'd2;
    step(0, 8'd0, 1, "R8");
    step(1, 8'd255, 0, "R10");
    check(triggered == 0, "R10", "first sample fired", int'(triggered), 0);
    step(1, 8'd200, 0, "R3");
    step(1, 8'd0, 0, "R3");
    step(1, 8'd10, 0, "R3");  // equal to level: fires
    check(triggered == 1 && qualOut == 8'd10, "R5", "trigger sample out", int'(qualOut), 10);

    // R6 with N=4, gaps inserted; R9 ratio change ignored
    relCount = 0;
    curRatio = 2'd0;  // R9: must not affect triggered run
    for (int i = 1; i <= 16; i++) begin
      step(1, 8'(i * 13), 0, "R6");
      if (i % 3 == 0) step(0, 8'hAA, 0, "R6");
    end
    check(relCount == 4, "R9", "releases over 16 valid at N=4", relCount, 4);
    // R7: crossings while triggered do not restart
    step(1, 8'd0, 0, "R7");
    step(1, 8'd50, 0, "R7");
    check(triggered == 1, "R7", "still triggered", int'(triggered), 1);

    // R8: arm with crossing in same cycle
    step(1, 8'd0, 0, "R8");
    step(1, 8'd50, 1, "R8");
    check(triggered == 0 && qualOut == 0, "R8", "arm clears", int'(triggered), 0);

    // R4: falling slope, N=1
    curSlope = 1; curLevel = 8'd100; curRatio = 2'd0;
    step(1, 8'd150, 0, "R4");
    step(1, 8'd100, 0, "R4");
    check(qualValid == 1 && qualOut == 8'd100, "R4", "falling fire", int'(qualOut), 100);
    relCount = 0;
    for (int i = 0; i < 6; i++) step(1, 8'(i + 1), 0, "R6");
    check(relCount == 6, "R6", "releases at N=1", relCount, 6);

    // R2: without arm, re-arm sequence after reset
    @(negedge clk); rstN = 1'b0; modelReset();
    @(negedge clk); rstN = 1'b1;
    curSlope = 0; curLevel = 8'd50;
    for (int i = 0; i < 8; i++) step(1, (i % 2) ? 8'd200 : 8'd0, 0, "R2");
    check(triggered == 0, "R2", "fired unarmed", int'(triggered), 0);

    // N=8 directed
    curRatio = 2'd3;
    step(0, 8'd0, 1, "R8");
    step(1, 8'd0, 0, "R6");
    step(1, 8'd60, 0, "R6");
    relCount = 0;
    for (int i = 0; i < 24; i++) step(1, 8'(i), 0, "R6");
    check(relCount == 3, "R6", "releases over 24 at N=8", relCount, 3);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic sv = ($urandom % 4) != 0;
      logic a = ($urandom % 60) == 0;
      if ($urandom % 50 == 0) curLevel = 8'($urandom);
      if ($urandom % 80 == 0) curSlope = ~curSlope;
      curRatio = 2'($urandom);
      step(sv, 8'($urandom), a, "R3");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule